// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the command bus of a two-bank SDRAM (11-bit row address, 8-bit column address) without ever driving it. On each rising clock edge it decodes the active-low chip select, RAS, CAS and WE pins, together with the two address bits that pick the bank and request automatic precharge. It keeps a small state machine per bank, plus device-wide refresh and mode-set busy windows, and judges every command against the state of the bank it targets.

All timing windows are given in clock cycles on configuration inputs. A command that breaks a rule raises a one-cycle error pulse with a code that names the broken rule. It also leaves the tracked state untouched, because the monitor treats an illegal command as if it never happened. The first error code is held until software-side logic pulses the clear input. All pins are plain level signals. Nothing is exchanged as a stream, so no handshake exists.

Top module: `sdcmd_guard`

## Requirements
- R1: The command is {cs_n, ras_n, cas_n, we_n}: 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 no operation, and cs_n=1 is deselect. No operation and deselect are never errors.
- R2: addr[11] selects the bank (0 = A, 1 = B). bank_state[2:0] holds bank A and bank_state[5:3] holds bank B, encoded 0 idle, 1 row opening, 2 row open, 3 read with auto-precharge, 4 write with auto-precharge, 5 precharging, 6 refreshing, 7 mode setting. A legal activate moves an idle bank to opening. A read or write to a bank that is idle or precharging gives code 2.
- R3: An activate to a bank that is not idle gives code 3.
- R4: A read or write issued fewer than cfg_trcd cycles after its bank's activate gives code 5. From cfg_trcd cycles onward, reads and writes to that open bank are legal.
- R5: A precharge with addr[10]=0 acts on the bank in addr[11]. With addr[10]=1 it acts on both banks. An open bank becomes precharging and is idle cfg_trp cycles after the command. A precharge to an idle or precharging bank is legal and changes nothing. A precharge reaching a bank that is still opening gives code 8.
- R6: An activate fewer than cfg_trrd cycles after the previous legal activate gives code 6.
- R7: A read or write with addr[10]=1 puts the bank into state 3 (read) or 4 (write). The bank stays there for cfg_burst cycles (read) or cfg_burst+cfg_twr cycles (write), then precharges for cfg_trp cycles. While the bank is in state 3 or 4, a read, write, activate or precharge to it gives code 4. A burst stop while any bank is in state 3 or 4 also gives code 4.
- R8: Mode set and refresh are legal only when both banks are idle; otherwise code 1.
- R9: A legal refresh puts both banks in state 6 until cfg_trc cycles after the command. A legal mode set puts both banks in state 7 for two cycles. Any command other than no operation or deselect during either window gives code 7.
- R10: err_pulse and err_code reflect the command of the previous cycle (err_code 0 when legal). An illegal command leaves both bank states as they would be with a no operation.
- R11: err_held and err_first capture the first error code. Later errors do not change them. err_clear empties them, unless an error arrives in the same cycle, in which case that error is captured.
- R12: After reset both banks are idle, err_pulse and err_held are 0, and both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Address bus; bit 11 bank, bit 10 auto/all precharge |
| cfg_trcd | input | 6 | Activate-to-access cycles |
| cfg_trp | input | 6 | Precharge duration cycles |
| cfg_trc | input | 6 | Refresh duration cycles |
| cfg_trrd | input | 6 | Activate-to-activate cycles |
| cfg_burst | input | 6 | Burst length in cycles |
| cfg_twr | input | 6 | Write recovery cycles |
| err_clear | input | 1 | Empties the first-error latch |
| bank_state | output | 6 | Per-bank state, 3 bits per bank |
| err_pulse | output | 1 | Illegal command seen last cycle |
| err_code | output | 4 | Rule broken last cycle, 0 if none |
| err_held | output | 1 | An error has been captured |
| err_first | output | 4 | Code of the first captured error |

## Verification
The assertions check on every cycle that no operation never raises an error, that a bank only starts opening on a legal activate, and that an auto-precharge state only ends in precharge or idle. They also check that both banks enter the refresh window together and that the first-error latch holds its code until it is cleared. What only the bench scenarios can show is the cycle arithmetic. Sweeps over the activate-to-access, precharge and activate-to-activate windows compare each error code with the expected outcome of "delay shorter than the configured count". Directed sequences cover auto-precharge read and write lifetimes, all-bank precharge, refresh and mode-set windows, and latch priority.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
  localparam int NUM_BANKS = 2;
  localparam int ST_W      = 3;

  typedef enum logic [3:0] {
    C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_BT, C_NOP, C_DESEL
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_RDAP    = 3'd3,
    B_WRAP    = 3'd4,
    B_PRECHG  = 3'd5,
    B_REFRESH = 3'd6,
    B_MODESET = 3'd7
  } bank_e;

  typedef enum logic [3:0] {
    E_NONE         = 4'd0,
    E_NOT_ALL_IDLE = 4'd1,
    E_ROW_CLOSED   = 4'd2,
    E_ROW_BUSY     = 4'd3,
    E_AP_LOCK      = 4'd4,
    E_RCD          = 4'd5,
    E_RRD          = 4'd6,
    E_DEV_BUSY     = 4'd7,
    E_PRE_EARLY    = 4'd8
  } err_e;

  typedef struct packed {
    cmd_e op;
    logic bank;
    logic a10;
  } dec_t;

  function automatic logic is_ap(input logic [ST_W-1:0] s);
    return (s == B_RDAP) || (s == B_WRAP);
  endfunction
endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic bank_bit,
  input  logic ap_bit,
  output dec_t dec
);
  always_comb begin
    dec.bank = bank_bit;
    dec.a10  = ap_bit;
    if (cs_n) begin
      dec.op = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  dec.op = C_MRS;
        3'b001:  dec.op = C_REF;
        3'b010:  dec.op = C_PRE;
        3'b011:  dec.op = C_ACT;
        3'b100:  dec.op = C_WR;
        3'b101:  dec.op = C_RD;
        3'b110:  dec.op = C_BT;
        default: dec.op = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_judge.sv
`timescale 1ns/1ps
module sdcmd_judge
  import sdcmd_pkg::*;
(
  input  dec_t                             dec,
  input  logic [NUM_BANKS-1:0][ST_W-1:0]   st,
  input  logic                             rrd_ok,
  output err_e                             code
);
  logic              any_busy, any_ap, all_idle, any_opening;
  logic [ST_W-1:0]   tgt;

  always_comb begin
    any_busy    = 1'b0;
    any_ap      = 1'b0;
    all_idle    = 1'b1;
    any_opening = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] == B_REFRESH || st[i] == B_MODESET) any_busy = 1'b1;
      if (is_ap(st[i]))        any_ap      = 1'b1;
      if (st[i] != B_IDLE)     all_idle    = 1'b0;
      if (st[i] == B_OPENING)  any_opening = 1'b1;
    end
  end

  assign tgt = st[dec.bank];

  always_comb begin
    code = E_NONE;
    if (dec.op != C_NOP && dec.op != C_DESEL) begin
      if (any_busy) begin
        code = E_DEV_BUSY;
      end else begin
        case (dec.op)
          C_MRS, C_REF: if (!all_idle) code = E_NOT_ALL_IDLE;
          C_PRE: begin
            if (dec.a10) begin
              if (any_ap)           code = E_AP_LOCK;
              else if (any_opening) code = E_PRE_EARLY;
            end else begin
              if (is_ap(tgt))              code = E_AP_LOCK;
              else if (tgt == B_OPENING)   code = E_PRE_EARLY;
            end
          end
          C_ACT: begin
            if (is_ap(tgt))           code = E_AP_LOCK;
            else if (tgt != B_IDLE)   code = E_ROW_BUSY;
            else if (!rrd_ok)         code = E_RRD;
          end
          C_RD, C_WR: begin
            if (is_ap(tgt))               code = E_AP_LOCK;
            else if (tgt == B_OPENING)    code = E_RCD;
            else if (tgt != B_OPEN)       code = E_ROW_CLOSED;
          end
          C_BT: if (any_ap) code = E_AP_LOCK;
          default: code = E_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
`timescale 1ns/1ps
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_act,
  input  logic            ev_ap,
  input  logic            ev_ap_wr,
  input  logic            ev_pre,
  input  logic            ev_ref,
  input  logic            ev_mrs,
  input  logic [TW-1:0]   cfg_trcd,
  input  logic [TW-1:0]   cfg_trp,
  input  logic [TW-1:0]   cfg_trc,
  input  logic [TW-1:0]   cfg_burst,
  input  logic [TW-1:0]   cfg_twr,
  output logic [ST_W-1:0] st_o
);
  localparam int CW = TW + 1;

  bank_e         st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] trcd_w, trp_w, trc_w, ap_len;

  assign trcd_w = {1'b0, cfg_trcd};
  assign trp_w  = {1'b0, cfg_trp};
  assign trc_w  = {1'b0, cfg_trc};

  always_comb begin
    ap_len = {1'b0, cfg_burst};
    if (ev_ap_wr) ap_len = ap_len + {1'b0, cfg_twr};
    if (ap_len == '0) ap_len = CW'(1);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      B_IDLE: begin
        if (ev_act) begin
          if (trcd_w >= CW'(2)) begin st_d = B_OPENING; cnt_d = trcd_w - CW'(2); end
          else                        st_d = B_OPEN;
        end else if (ev_ref) begin
          if (trc_w >= CW'(2)) begin st_d = B_REFRESH; cnt_d = trc_w - CW'(2); end
        end else if (ev_mrs) begin
          st_d  = B_MODESET;
          cnt_d = '0;
        end
      end
      B_OPENING: begin
        if (cnt_q == '0) st_d = B_OPEN;
        else             cnt_d = cnt_q - CW'(1);
      end
      B_OPEN: begin
        if (ev_ap) begin
          st_d  = ev_ap_wr ? B_WRAP : B_RDAP;
          cnt_d = ap_len - CW'(1);
        end else if (ev_pre) begin
          if (trp_w >= CW'(2)) begin st_d = B_PRECHG; cnt_d = trp_w - CW'(2); end
          else                       st_d = B_IDLE;
        end
      end
      B_RDAP, B_WRAP: begin
        if (cnt_q == '0) begin
          if (trp_w >= CW'(2)) begin st_d = B_PRECHG; cnt_d = trp_w - CW'(2); end
          else                       st_d = B_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (cnt_q == '0) st_d = B_IDLE;
        else             cnt_d = cnt_q - CW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;

  AST_OPEN_FROM_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != B_OPENING && !ev_act) |=> (st_q != B_OPENING)); // R2

  AST_AP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == B_RDAP || st_q == B_WRAP) |=>
      (st_q == B_RDAP || st_q == B_WRAP || st_q == B_PRECHG || st_q == B_IDLE)); // R7
endmodule

// File: rtl/sdcmd_guard.sv
`timescale 1ns/1ps
module sdcmd_guard
  import sdcmd_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int TW    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [ROW_W:0]            addr,
  input  logic [TW-1:0]             cfg_trcd,
  input  logic [TW-1:0]             cfg_trp,
  input  logic [TW-1:0]             cfg_trc,
  input  logic [TW-1:0]             cfg_trrd,
  input  logic [TW-1:0]             cfg_burst,
  input  logic [TW-1:0]             cfg_twr,
  input  logic                      err_clear,
  output logic [NUM_BANKS*ST_W-1:0] bank_state,
  output logic                      err_pulse,
  output logic [3:0]                err_code,
  output logic                      err_held,
  output logic [3:0]                err_first
);
  localparam int BANK_BIT = ROW_W;
  localparam int AP_BIT   = ROW_W - 1;

  dec_t                           dec;
  err_e                           judged;
  logic [NUM_BANKS-1:0][ST_W-1:0] st;
  logic [TW-1:0]                  gap_q;
  logic                           rrd_ok, legal;
  logic                           unused_addr;

  assign unused_addr = ^addr[AP_BIT-1:0];

  sdcmd_decode u_decode (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank_bit(addr[BANK_BIT]), .ap_bit(addr[AP_BIT]), .dec(dec)
  );

  sdcmd_judge u_judge (
    .dec(dec), .st(st), .rrd_ok(rrd_ok), .code(judged)
  );

  assign legal = (judged == E_NONE);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (dec.bank == b[0]);
      sdcmd_bank #(.TW(TW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ev_act  (legal && dec.op == C_ACT && hit),
        .ev_ap   (legal && (dec.op == C_RD || dec.op == C_WR) && dec.a10 && hit),
        .ev_ap_wr(dec.op == C_WR),
        .ev_pre  (legal && dec.op == C_PRE && (dec.a10 || hit)),
        .ev_ref  (legal && dec.op == C_REF),
        .ev_mrs  (legal && dec.op == C_MRS),
        .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trc(cfg_trc),
        .cfg_burst(cfg_burst), .cfg_twr(cfg_twr),
        .st_o(st[b])
      );
      assign bank_state[b*ST_W +: ST_W] = st[b];
    end
  endgenerate

  // cycles since last legal activate, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_q <= '1;
    else if (legal && dec.op == C_ACT)   gap_q <= TW'(1);
    else if (gap_q != '1)                gap_q <= gap_q + TW'(1);
  end
  assign rrd_ok = (gap_q >= cfg_trrd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_code  <= 4'd0;
      err_held  <= 1'b0;
      err_first <= 4'd0;
    end else begin
      err_pulse <= !legal;
      err_code  <= judged;
      if (!legal && (!err_held || err_clear)) begin
        err_held  <= 1'b1;
        err_first <= judged;
      end else if (err_clear) begin
        err_held  <= 1'b0;
        err_first <= 4'd0;
      end
    end
  end

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == C_NOP || dec.op == C_DESEL) |=> !err_pulse); // R1

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_held && !err_clear) |=> (err_held && $stable(err_first))); // R11

  AST_REFRESH_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] == B_REFRESH) == (st[1] == B_REFRESH)); // R9

  AST_MODESET_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] == B_MODESET) == (st[1] == B_MODESET)); // R9
endmodule

// File: tb/sdcmd_guard_bench.sv
`timescale 1ns/1ps
module sdcmd_guard_bench;
  localparam logic [3:0] MRS = 4'b0000, REF = 4'b0001, PRE = 4'b0010, ACT = 4'b0011,
                         WR = 4'b0100, RD = 4'b0101, BT = 4'b0110, NOP = 4'b0111,
                         DSL = 4'b1111;
  localparam logic [11:0] BA = 12'h000, BB = 12'h800, APF = 12'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [5:0] cfg_trcd = 6'd3, cfg_trp = 6'd2, cfg_trc = 6'd3, cfg_trrd = 6'd2;
  logic [5:0] cfg_burst = 6'd2, cfg_twr = 6'd1;
  logic err_clear = 1'b0;
  logic [5:0] bank_state;
  logic err_pulse, err_held;
  logic [3:0] err_code, err_first;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  sdcmd_guard u_sdcmd_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trc(cfg_trc),
    .cfg_trrd(cfg_trrd), .cfg_burst(cfg_burst), .cfg_twr(cfg_twr),
    .err_clear(err_clear), .bank_state(bank_state), .err_pulse(err_pulse),
    .err_code(err_code), .err_held(err_held), .err_first(err_first)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = DSL;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(NOP, BA);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    check("R12 state", bank_state, 0);
    check("R12 pulse", err_pulse, 0);
    check("R12 held", err_held, 0);
    check("R12 first", err_first, 0);

    // R1 idle commands
    issue(NOP, BA);  check("R1 nop", err_code, 0);
    issue(DSL, BB);  check("R1 deselect", err_code, 0);

    // R2 read to idle bank; R10 no state change
    issue(RD, BA);
    check("R2 rd idle code", err_code, 2);
    check("R10 pulse", err_pulse, 1);
    check("R10 state kept", bank_state, 0);
    issue(NOP, BA);  check("R10 pulse one cycle", err_pulse, 0);

    // R2 activate A, opening; R6 activate B too soon
    issue(ACT, BA);  check("R2 act opening", bank_state[2:0], 1);
    issue(ACT, BB);  check("R6 rrd code", err_code, 6);
    check("R10 B still idle", bank_state[5:3], 0);
    issue(RD, BA);   check("R4 rcd code", err_code, 5);
    check("R4 now open", bank_state[2:0], 2);
    issue(ACT, BA);  check("R3 act open bank", err_code, 3);
    issue(RD, BA);   check("R4 rd open legal", err_code, 0);
    issue(REF, BA);  check("R8 ref bank open", err_code, 1);
    issue(MRS, BA);  check("R8 mrs bank open", err_code, 1);
    issue(PRE, BA);  check("R5 pre single", bank_state[2:0], 5);
    issue(PRE, BA);  check("R5 pre to precharging legal", err_code, 0);
    check("R5 idle after trp", bank_state[2:0], 0);
    // R11 latch keeps first
    check("R11 held", err_held, 1);
    check("R11 first kept", err_first, 2);
    err_clear = 1'b1; issue(NOP, BA); err_clear = 1'b0;
    check("R11 cleared held", err_held, 0);
    check("R11 cleared code", err_first, 0);
    err_clear = 1'b1; issue(WR, BB); err_clear = 1'b0;
    check("R11 clear with error", err_first, 2);
    err_clear = 1'b1; issue(NOP, BA); err_clear = 1'b0;

    // R7 read with auto-precharge on B: burst 2, trp 2
    issue(ACT, BB);  nops(3);
    check("R7 B open", bank_state[5:3], 2);
    issue(RD, BB | APF); check("R7 rdap state", bank_state[5:3], 3);
    issue(ACT, BB);  check("R7 act during ap", err_code, 4);
    check("R7 still rdap", bank_state[5:3], 3);
    issue(BT, BA);   check("R7 bt during ap", err_code, 4);
    check("R7 rdap to prechg", bank_state[5:3], 5);
    issue(NOP, BA);  check("R7 rdap idle", bank_state[5:3], 0);

    // R7 write with auto-precharge: burst 2 + twr 1
    issue(ACT, BB);  nops(3);
    issue(WR, BB | APF); check("R7 wrap t1", bank_state[5:3], 4);
    issue(PRE, BB);  check("R7 pre during ap", err_code, 4);
    issue(NOP, BA);  check("R7 wrap t3", bank_state[5:3], 4);
    issue(NOP, BA);  check("R7 wrap prechg", bank_state[5:3], 5);
    issue(NOP, BA);  check("R7 wrap idle", bank_state[5:3], 0);

    // R5 precharge all, and early precharge
    issue(ACT, BA);  issue(NOP, BA);
    issue(ACT, BB);  check("R6 act after trrd", err_code, 0);
    issue(PRE, BA | APF); check("R5 pre all while B opening", err_code, 8);
    nops(3);
    issue(PRE, BB | APF); check("R5 pre all A", bank_state[2:0], 5);
    check("R5 pre all B", bank_state[5:3], 5);
    issue(NOP, BA);  check("R5 pre all idle", bank_state, 0);

    // R9 refresh window, trc 3
    issue(REF, BA);  check("R9 refresh state", bank_state, 6'o66);
    issue(ACT, BA);  check("R9 act in refresh", err_code, 7);
    issue(NOP, BA);  check("R9 refresh ends", bank_state, 0);
    issue(MRS, BA);  check("R9 modeset state", bank_state, 6'o77);
    issue(RD, BB);   check("R9 rd in modeset", err_code, 7);
    check("R9 modeset ends", bank_state, 0);
    issue(MRS, BA);  check("R8 mrs both idle", err_code, 0);
    nops(2);

    // R4 sweep over trcd and delay
    for (int t = 1; t <= 4; t++) begin
      for (int k = 1; k <= 5; k++) begin
        do_reset();
        cfg_trcd = 6'(t);
        issue(ACT, BA);
        nops(k - 1);
        issue(WR, BA);
        check($sformatf("R4 sweep trcd=%0d k=%0d", t, k), err_code, (k < t) ? 5 : 0);
      end
    end

    // R5 sweep over trp
    cfg_trcd = 6'd1; cfg_trrd = 6'd0;
    for (int t = 1; t <= 4; t++) begin
      for (int k = 1; k <= 5; k++) begin
        do_reset();
        cfg_trp = 6'(t);
        issue(ACT, BB);
        issue(PRE, BB);
        nops(k - 1);
        issue(ACT, BB);
        check($sformatf("R5 sweep trp=%0d k=%0d", t, k), err_code, (k < t) ? 3 : 0);
      end
    end

    // R6 sweep over trrd
    for (int t = 0; t <= 3; t++) begin
      for (int k = 1; k <= 4; k++) begin
        do_reset();
        cfg_trrd = 6'(t);
        issue(ACT, BA);
        nops(k - 1);
        issue(ACT, BB);
        check($sformatf("R6 sweep trrd=%0d k=%0d", t, k), err_code, (k < t) ? 6 : 0);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule